// File: doc/BRIEF.md
# Cascaded external interrupt controller

This block collects a bank of external interrupt lines and funnels them into one request line towards an upstream interrupt controller. Every source owns a pair of 32-bit configuration words. The first word carries a two-bit enable field and a two-bit sense selector. Its remaining bits, and the whole second word, hold values such as priority and target node that software stores and reads back; the block itself does not act on them.

Most sources are level sensitive. A small, parameterised window of sources can also latch rising or falling edges. Software clears those latches by writing to one shared register, using the source number modulo 16 as the index.

Software works through a simple 32-bit register port: one request per cycle, with read data registered on the next clock edge. When detection is on, the block scans all pending sources and exposes the lowest-numbered one in the top byte of a status word, using the code 63 for "nothing pending". The upstream line asserts when a source is pending and both the detection enable and the forwarding enable are set.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, detection and forwarding are off, `cascade_o` is low and the status word (0x144) reads 0x3F000000.
- R2: A read request presents its data on `bus_rdata` after the next rising clock edge, and `bus_rdata` holds otherwise. Source n's first and second configuration words sit at byte offsets 0x200+8n and 0x204+8n and read back the full written value.
- R3: A source can be reported only when bits 29 and 28 of its first configuration word are both 1; with either bit clear it is masked.
- R4: For level sensing, bit 24 of the first word selects the polarity (1 = pending while high, 0 = pending while low). On sources outside the edge window, bit 25 is ignored.
- R5: On sources EDGE_FIRST to EDGE_FIRST+EDGE_COUNT-1 (47 to 50 by default), sense code 3 in bits 25:24 latches a rising edge and code 2 latches a falling edge. A latched edge keeps the source pending after the input returns. A new edge and a clear in the same cycle leave the latch set.
- R6: A write to offset 0x0C0 with bit 8 set clears the edge latch of the edge-window source whose number modulo 16 equals bits 3:0 of the written value. With bit 8 clear the write has no effect.
- R7: Offset 0x144 returns, in bits 31:24, the lowest-numbered pending source, or 63 when none is pending; bits 23:0 read zero.
- R8: Bit 0 at offset 0x004 enables detection. While it is 0 no source is reported and `cascade_o` stays low.
- R9: `cascade_o` is registered. One cycle after the block is in that state, it equals the AND of bit 0 at offset 0x444, the detection enable and "some source pending".
- R10: Offset 0x084 is a level-mask word that resets to zero, reads back what was written and does not change which source is reported.
- R11: Offset 0x484 reads the DEV_ID parameter. Every other offset without a register, including unaligned addresses and offset 0x0C0, reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | NUM_SRC | External interrupt lines, synchronous to clk |
| cascade_o | output | 1 | Request to the upstream controller |

## Verification
The bench builds the block with NUM_SRC = 64, EDGE_FIRST = 47 and EDGE_COUNT = 4, and overrides DEV_ID with a distinctive value. With these settings source 63 can be pending at the same time that the status reports the "none" code, so only `cascade_o` tells the two apart. The edge window also straddles a modulo-16 wrap (47 maps to clear index 15, while 48 to 50 map to 0 to 2), which makes a wrong clear index visible. A behavioural model advances with every clock and is compared against both outputs, alongside directed reads at each corner.

// File: rtl/eic_pkg.sv
package eic_pkg;

    localparam logic [11:0] OFF_DETECT   = 12'h004;
    localparam logic [11:0] OFF_LVLMASK  = 12'h084;
    localparam logic [11:0] OFF_EDGECLR  = 12'h0C0;
    localparam logic [11:0] OFF_STATUS   = 12'h144;
    localparam logic [11:0] OFF_CFG_BASE = 12'h200;
    localparam logic [11:0] OFF_FWD      = 12'h444;
    localparam logic [11:0] OFF_DEVID    = 12'h484;

    localparam int EN_HI      = 29;
    localparam int EN_LO      = 28;
    localparam int SENSE_HI   = 25;
    localparam int SENSE_LO   = 24;
    localparam int CLR_GO_BIT = 8;
    localparam int STAT_W     = 8;

    typedef enum logic [1:0] {
        SENSE_LVL_LOW  = 2'd0,
        SENSE_LVL_HIGH = 2'd1,
        SENSE_FALL     = 2'd2,
        SENSE_RISE     = 2'd3
    } sense_e;

endpackage

// File: rtl/eic_edge_cell.sv
module eic_edge_cell
    import eic_pkg::*;
#(
    parameter logic [3:0] CLR_CODE = 4'd0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_in,
    input  logic [1:0] sense,
    input  logic       clr_go,
    input  logic [3:0] clr_sel,
    output logic       latch_o
);

    typedef struct packed {
        logic prev;
        logic latch;
    } cell_t;

    cell_t q, d;
    logic  edge_now;
    logic  clr_hit;

    always_comb begin
        clr_hit  = clr_go && (clr_sel == CLR_CODE);
        edge_now = ((sense == SENSE_RISE) &&  irq_in && !q.prev) ||
                   ((sense == SENSE_FALL) && !irq_in &&  q.prev);
        d        = q;
        d.prev   = irq_in;
        if (edge_now) begin
            d.latch = 1'b1;
        end else if (clr_hit) begin
            d.latch = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign latch_o = q.latch;

    // R5: a detected edge is captured
    a_r5_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        edge_now |=> latch_o);

    // R5: a captured edge persists until cleared
    a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_o && !clr_hit) |=> latch_o);

    // R6: a matching clear without a new edge empties the latch
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !edge_now) |=> !latch_o);

endmodule

// File: rtl/eic_lowest_sel.sv
module eic_lowest_sel #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     pend,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [IDX_W-1:0] NONE_CODE = IDX_W'(N - 1);

    always_comb begin
        idx_o = NONE_CODE;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx_o = IDX_W'(i);
            end
        end
        any_o = |pend;
    end

    logic below_pending;
    always_comb begin
        below_pending = 1'b0;
        for (int j = 0; j < N; j++) begin
            if ((j < int'(idx_o)) && pend[j]) begin
                below_pending = 1'b1;
            end
        end
    end

    // R7: no pending source has a lower number than the one reported
    a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        !below_pending);

    // R7: the reported source really is pending
    a_r7_pick_pending: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> pend[idx_o]);

    // R7: the none code is reported when nothing is pending
    a_r7_none_code: assert property (@(posedge clk) disable iff (!rst_n)
        !any_o |-> (idx_o == NONE_CODE));

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import eic_pkg::*;
#(
    parameter int          NUM_SRC    = 64,
    parameter int          EDGE_FIRST = 47,
    parameter int          EDGE_COUNT = 4,
    parameter logic [31:0] DEV_ID     = 32'h0005_1D00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] irq_in,
    output logic               cascade_o
);

    localparam int          IDX_W   = $clog2(NUM_SRC);
    localparam logic [12:0] CFG_END = 13'(OFF_CFG_BASE) + 13'(8 * NUM_SRC);

    typedef struct packed {
        logic                    det_en;
        logic                    fwd_en;
        logic [31:0]             lvl_mask;
        logic [NUM_SRC-1:0][31:0] cfg_a;
        logic [NUM_SRC-1:0][31:0] cfg_b;
        logic [31:0]             rdata;
        logic                    cascade;
    } state_t;

    state_t q, d;

    // ---------------- address decode ----------------
    logic             rd_req, wr_req;
    logic             cfg_hit;
    logic [11:0]      cfg_off;
    logic [IDX_W-1:0] cfg_idx;
    logic             cfg_word;
    logic             clr_go;

    always_comb begin
        rd_req   = bus_sel && !bus_we;
        wr_req   = bus_sel &&  bus_we;
        cfg_off  = bus_addr - OFF_CFG_BASE;
        cfg_idx  = IDX_W'(cfg_off >> 3);
        cfg_word = cfg_off[2];
        cfg_hit  = (bus_addr >= OFF_CFG_BASE) && ({1'b0, bus_addr} < CFG_END) &&
                   (bus_addr[1:0] == 2'b00);
        clr_go   = wr_req && (bus_addr == OFF_EDGECLR) && bus_wdata[CLR_GO_BIT];
    end

    // ---------------- per-source pending ----------------
    logic [NUM_SRC-1:0] pend;

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
        logic match_w;
        logic cond_w;

        assign match_w = (irq_in[n] == q.cfg_a[n][SENSE_LO]);

        if ((n >= EDGE_FIRST) && (n < EDGE_FIRST + EDGE_COUNT)) begin : g_edge
            logic latch_w;

            eic_edge_cell #(
                .CLR_CODE(4'(n % 16))
            ) u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .irq_in  (irq_in[n]),
                .sense   (q.cfg_a[n][SENSE_HI:SENSE_LO]),
                .clr_go  (clr_go),
                .clr_sel (bus_wdata[3:0]),
                .latch_o (latch_w)
            );

            assign cond_w = q.cfg_a[n][SENSE_HI] ? latch_w : match_w;
        end else begin : g_lvl
            assign cond_w = match_w;
        end

        assign pend[n] = q.det_en && (&q.cfg_a[n][EN_HI:EN_LO]) && cond_w;
    end

    // ---------------- lowest-number selection ----------------
    logic             any_pend;
    logic [IDX_W-1:0] sel_idx;

    eic_lowest_sel #(
        .N     (NUM_SRC),
        .IDX_W (IDX_W)
    ) u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend),
        .any_o (any_pend),
        .idx_o (sel_idx)
    );

    // ---------------- read mux ----------------
    logic [31:0] rd_mux;

    always_comb begin
        case (bus_addr)
            OFF_DETECT:  rd_mux = {31'b0, q.det_en};
            OFF_LVLMASK: rd_mux = q.lvl_mask;
            OFF_STATUS:  rd_mux = {STAT_W'(sel_idx), 24'b0};
            OFF_FWD:     rd_mux = {31'b0, q.fwd_en};
            OFF_DEVID:   rd_mux = DEV_ID;
            default: begin
                if (cfg_hit) begin
                    rd_mux = cfg_word ? q.cfg_b[cfg_idx] : q.cfg_a[cfg_idx];
                end else begin
                    rd_mux = 32'b0;
                end
            end
        endcase
    end

    // ---------------- next state ----------------
    always_comb begin
        d         = q;
        d.cascade = q.fwd_en && any_pend;
        if (rd_req) begin
            d.rdata = rd_mux;
        end
        if (wr_req) begin
            if (bus_addr == OFF_DETECT) begin
                d.det_en = bus_wdata[0];
            end else if (bus_addr == OFF_LVLMASK) begin
                d.lvl_mask = bus_wdata;
            end else if (bus_addr == OFF_FWD) begin
                d.fwd_en = bus_wdata[0];
            end else if (cfg_hit) begin
                if (cfg_word) begin
                    d.cfg_b[cfg_idx] = bus_wdata;
                end else begin
                    d.cfg_a[cfg_idx] = bus_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign bus_rdata = q.rdata;
    assign cascade_o = q.cascade;

    // R9: the upstream line only rises when both enables were set
    a_r9_cascade_gated: assert property (@(posedge clk) disable iff (!rst_n)
        cascade_o |-> $past(q.fwd_en && q.det_en));

    // R9: a pending source with forwarding on raises the line next cycle
    a_r9_cascade_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fwd_en && any_pend) |=> cascade_o);

    // R8: detection off means nothing pending is seen
    a_r8_det_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !q.det_en |=> !cascade_o);

    // R2: read data holds when no read is requested
    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(bus_rdata));

endmodule

// File: tb/ext_irq_ctrl_tb.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb;

    localparam logic [31:0] TB_DEV_ID = 32'hC0DE_0042;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] irq = '0;
    logic        cascade_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ext_irq_ctrl #(
        .NUM_SRC    (64),
        .EDGE_FIRST (47),
        .EDGE_COUNT (4),
        .DEV_ID     (TB_DEV_ID)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_in    (irq),
        .cascade_o (cascade_o)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_cfga [64];
    logic [31:0] m_cfgb [64];
    logic        m_det, m_fwd;
    logic [31:0] m_mask;
    logic        m_latch [4];
    logic        m_prev [64];
    logic [31:0] exp_rdata;
    logic        exp_casc;

    function automatic logic m_pending(int s);
        logic hit;
        if (m_cfga[s][29:28] != 2'b11 || !m_det) return 1'b0;
        if (s >= 47 && s <= 50 && m_cfga[s][25]) hit = m_latch[s - 47];
        else hit = (irq[s] == m_cfga[s][24]);
        return hit;
    endfunction

    function automatic logic [31:0] m_read(logic [11:0] a, int lowest);
        int ai;
        ai = int'(a);
        if (ai == 'h004) return {31'b0, m_det};
        if (ai == 'h084) return m_mask;
        if (ai == 'h144) return 32'(lowest) << 24;
        if (ai == 'h444) return {31'b0, m_fwd};
        if (ai == 'h484) return TB_DEV_ID;
        if (ai >= 'h200 && ai < 'h400 && (ai % 4) == 0) begin
            if (((ai / 4) % 2) == 1) return m_cfgb[(ai - 'h200) / 8];
            return m_cfga[(ai - 'h200) / 8];
        end
        return 32'b0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) begin
                m_cfga[i] = '0; m_cfgb[i] = '0; m_prev[i] = 1'b0;
            end
            for (int k = 0; k < 4; k++) m_latch[k] = 1'b0;
            m_det = 0; m_fwd = 0; m_mask = '0;
            exp_rdata = '0; exp_casc = 1'b0;
        end else begin
            int  lowest;
            logic anyp;
            lowest = 63; anyp = 1'b0;
            for (int s = 63; s >= 0; s--) begin
                if (m_pending(s)) begin lowest = s; anyp = 1'b1; end
            end
            if (bus_sel && !bus_we) exp_rdata = m_read(bus_addr, lowest);
            exp_casc = m_fwd && m_det && anyp;
            for (int k = 0; k < 4; k++) begin
                int  s;
                logic edg, clr;
                s   = 47 + k;
                edg = (m_cfga[s][25:24] == 2'd3 && irq[s] && !m_prev[s]) ||
                      (m_cfga[s][25:24] == 2'd2 && !irq[s] && m_prev[s]);
                clr = bus_sel && bus_we && bus_addr == 12'h0C0 && bus_wdata[8] &&
                      int'(bus_wdata[3:0]) == (s % 16);
                if (edg) m_latch[k] = 1'b1;
                else if (clr) m_latch[k] = 1'b0;
            end
            if (bus_sel && bus_we) begin
                int ai;
                ai = int'(bus_addr);
                if (ai == 'h004) m_det = bus_wdata[0];
                else if (ai == 'h084) m_mask = bus_wdata;
                else if (ai == 'h444) m_fwd = bus_wdata[0];
                else if (ai >= 'h200 && ai < 'h400 && (ai % 4) == 0) begin
                    if (((ai / 4) % 2) == 1) m_cfgb[(ai - 'h200) / 8] = bus_wdata;
                    else m_cfga[(ai - 'h200) / 8] = bus_wdata;
                end
            end
            for (int i = 0; i < 64; i++) m_prev[i] = irq[i];
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R9 cascade vs model", {31'b0, cascade_o}, {31'b0, exp_casc});
            chk("R2 rdata vs model", bus_rdata, exp_rdata);
        end
    end

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        finish_up();
    end

    task automatic wr(logic [11:0] a, logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        v = bus_rdata;
    endtask

    task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic set_irq(int s, logic v);
        @(negedge clk);
        irq[s] = v;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_chk("R1 status", 12'h144, 32'h3F00_0000);
        rd_chk("R1 cfg0", 12'h200, 32'h0);
        rd_chk("R1 detect", 12'h004, 32'h0);
        rd_chk("R1 forward", 12'h444, 32'h0);
        rd_chk("R1 mask", 12'h084, 32'h0);
        chk("R1 cascade", {31'b0, cascade_o}, 32'h0);

        // R2: configuration words read back
        wr(12'h22C, 32'h0002_0005);
        rd_chk("R2 cfg5 second word", 12'h22C, 32'h0002_0005);
        wr(12'h228, 32'h3107_0E5E);
        rd_chk("R2 cfg5 first word", 12'h228, 32'h3107_0E5E);
        wr(12'h228, 32'h3100_0000);

        wr(12'h004, 32'h1);
        wr(12'h444, 32'h1);
        set_irq(5, 1'b1);
        rd_chk("R7 single source", 12'h144, 32'h0500_0000);
        chk("R9 cascade up", {31'b0, cascade_o}, 32'h1);

        // R3: half enable keeps source masked
        wr(12'h218, 32'h1100_0000);
        set_irq(3, 1'b1);
        rd_chk("R3 half enable", 12'h144, 32'h0500_0000);
        wr(12'h218, 32'h2100_0000);
        rd_chk("R3 other half", 12'h144, 32'h0500_0000);

        // R4: active-low level and ignored bit 25
        wr(12'h210, 32'h3000_0000);
        rd_chk("R4 active low pends", 12'h144, 32'h0200_0000);
        wr(12'h210, 32'h3200_0000);
        rd_chk("R4 bit25 ignored", 12'h144, 32'h0200_0000);
        set_irq(2, 1'b1);
        rd_chk("R4 low level released", 12'h144, 32'h0500_0000);

        // R8: detection off
        wr(12'h004, 32'h0);
        @(negedge clk);
        rd_chk("R8 status none", 12'h144, 32'h3F00_0000);
        chk("R8 cascade low", {31'b0, cascade_o}, 32'h0);
        wr(12'h004, 32'h1);

        // R9: forwarding off
        wr(12'h444, 32'h0);
        @(negedge clk);
        chk("R9 forward off", {31'b0, cascade_o}, 32'h0);
        rd_chk("R9 status still set", 12'h144, 32'h0500_0000);
        wr(12'h444, 32'h1);

        wr(12'h228, 32'h0);
        wr(12'h218, 32'h0);
        wr(12'h210, 32'h0);
        irq = '0;
        rd_chk("R7 none pending", 12'h144, 32'h3F00_0000);

        // R5/R6: rising edge on 48
        wr(12'h380, 32'h3300_0000);
        set_irq(48, 1'b1);
        set_irq(48, 1'b0);
        rd_chk("R5 rising held", 12'h144, 32'h3000_0000);
        wr(12'h0C0, 32'h0000_0000);
        rd_chk("R6 no go bit", 12'h144, 32'h3000_0000);
        wr(12'h0C0, 32'h0000_0101);
        rd_chk("R6 other index", 12'h144, 32'h3000_0000);
        wr(12'h0C0, 32'h0000_0100);
        rd_chk("R6 cleared", 12'h144, 32'h3F00_0000);
        wr(12'h380, 32'h0);

        // R5/R6: falling edge on 47 (clear index 15)
        set_irq(47, 1'b1);
        wr(12'h378, 32'h3200_0000);
        rd_chk("R5 no fall yet", 12'h144, 32'h3F00_0000);
        set_irq(47, 1'b0);
        rd_chk("R5 falling held", 12'h144, 32'h2F00_0000);
        wr(12'h0C0, 32'h0000_010F);
        rd_chk("R6 wrap index cleared", 12'h144, 32'h3F00_0000);
        wr(12'h378, 32'h0);

        // R7/R9: source 63 aliases the none code
        wr(12'h3F8, 32'h3100_0000);
        set_irq(63, 1'b1);
        rd_chk("R7 source 63", 12'h144, 32'h3F00_0000);
        chk("R9 cascade for 63", {31'b0, cascade_o}, 32'h1);
        wr(12'h3F8, 32'h0);
        irq[63] = 1'b0;

        // R10: mask word
        wr(12'h084, 32'h0000_00A5);
        rd_chk("R10 mask readback", 12'h084, 32'h0000_00A5);
        wr(12'h228, 32'h3100_0000);
        set_irq(5, 1'b1);
        rd_chk("R10 mask no effect", 12'h144, 32'h0500_0000);

        // R11: fixed and empty offsets
        rd_chk("R11 device id", 12'h484, TB_DEV_ID);
        rd_chk("R11 empty offset", 12'h600, 32'h0);
        rd_chk("R11 clear reg reads zero", 12'h0C0, 32'h0);
        rd_chk("R11 unaligned", 12'h229, 32'h0);
        rd_chk("R11 past cfg range", 12'h400, 32'h0);

        repeat (3) @(negedge clk);
        finish_up();
    end

endmodule